// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block derives the serial clock for a SPI shift engine from a fixed reference clock (nominally 200 MHz). A 4-bit rate code selects one of several fixed divide ratios. One code passes control to a separate 6-bit programmable divider. A separate force bit overrides both and selects the fastest rate, divide-by-2. Alongside the clock level, the block produces one-cycle rise and fall strobes that the shift engine can use as clock enables.

Configuration arrives through a small write-only register port and is held in staging registers. The running divide ratio changes only at the end of a serial-clock period, and only while the shift engine reports idle. This keeps a command in flight at one rate and stops any shortened or stretched clock pulse from reaching the bus. Each period starts with its low phase. When the ratio is odd, the high phase is one reference cycle shorter than the low phase.

Top module: `spi_rate_gen`

## Requirements
- R1: After reset, `sclk`, `sclkRise` and `sclkFall` are low and the generator runs at divide-by-250, the slowest rate.
- R2: With the force bit clear, rate codes 0, 1, 2, 3, 4 and 5 give serial-clock periods of 3, 6, 9, 12, 2 and 250 reference cycles respectively.
- R3: Rate code 7 gives a period equal to the 6-bit divider field value N, for N from 2 to 63.
- R4: With rate code 7, a divider field value of 0 or 1 gives a period of 2 reference cycles.
- R5: Reserved rate codes (6 and 8 to 15) give a period of 250 reference cycles.
- R6: When the force bit is set, the period is 2 reference cycles whatever the rate code.
- R7: Each period of N cycles consists of ceil(N/2) low cycles followed by floor(N/2) high cycles.
- R8: `sclkRise` is high for exactly the cycle in which `sclk` first reads high, and `sclkFall` for exactly the cycle in which it first reads low. The two strobes are never high together.
- R9: A new setting takes effect only at a period boundary while `engineBusy` is low. While `engineBusy` is high, the previous rate continues unchanged.
- R10: The divider field has no effect on the rate unless rate code 7 is selected.
- R11: The register port has two addresses. Address 0 holds the mode: `cfgWdata[3:0]` is the rate code and `cfgWdata[4]` is the force bit. Address 1 holds the divider field in `cfgWdata[5:0]`. A write happens on a cycle with `cfgWe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| engineBusy | input | 1 | High while the shift engine runs a command; blocks rate changes |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 1 | Register select: 0 mode, 1 divider field |
| cfgWdata | input | 6 | Configuration write data |
| sclk | output | 1 | Serial clock level |
| sclkRise | output | 1 | One-cycle strobe on the cycle `sclk` goes high |
| sclkFall | output | 1 | One-cycle strobe on the cycle `sclk` goes low |

## Verification
The checker watches every cycle for the link between the strobes and the clock level. It also checks that the two strobes are never high together, that a ratio load happens only at a period boundary with the engine idle, and that every period opens with a low phase. The bench's scenarios are the only place the decoded ratios appear. They measure period and high-phase length for each fixed code, each divider value, the reserved codes and the force bit. They also show that a setting written while the engine is busy stays dormant until the engine goes idle.

// File: rtl/spi_rate_gen_pkg.sv
package spi_rate_gen_pkg;

  parameter int CODE_W = 4;
  parameter int DIVF_W = 6;
  parameter int DIV_W  = 8;
  parameter int CFG_W  = 6;

  parameter int DIV_C0   = 3;
  parameter int DIV_C1   = 6;
  parameter int DIV_C2   = 9;
  parameter int DIV_C3   = 12;
  parameter int DIV_C4   = 2;
  parameter int DIV_C5   = 250;
  parameter int DIV_MIN  = 2;
  parameter int DIV_SLOW = 250;
  parameter int CODE_PROG = 7;

  typedef struct packed {
    logic wrap;   // current period ends this cycle
    logic load;   // adopt the staged ratio at this boundary
  } rateStrobe_t;

  function automatic logic [DIV_W-1:0] decodeRatio(
    input logic [CODE_W-1:0] code,
    input logic              force2,
    input logic [DIVF_W-1:0] divField
  );
    logic [DIV_W-1:0] r;
    case (code)
      CODE_W'(0): r = DIV_W'(DIV_C0);
      CODE_W'(1): r = DIV_W'(DIV_C1);
      CODE_W'(2): r = DIV_W'(DIV_C2);
      CODE_W'(3): r = DIV_W'(DIV_C3);
      CODE_W'(4): r = DIV_W'(DIV_C4);
      CODE_W'(5): r = DIV_W'(DIV_C5);
      CODE_W'(CODE_PROG):
        r = (divField < DIVF_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : DIV_W'(divField);
      default:    r = DIV_W'(DIV_SLOW);
    endcase
    if (force2) r = DIV_W'(DIV_MIN);
    return r;
  endfunction

endpackage

// File: rtl/spi_rate_gen_ctrl.sv
module spi_rate_gen_ctrl
  import spi_rate_gen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic        engineBusy,
  input  logic        lastCnt,
  output rateStrobe_t stb
);

  logic pending;

  always_comb begin
    stb.wrap = lastCnt;
    stb.load = lastCnt && !engineBusy && pending;
  end

  // A write arms the update; a load consumes it unless a write lands on the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)         pending <= 1'b0;
    else if (cfgWe)    pending <= 1'b1;
    else if (stb.load) pending <= 1'b0;
  end

endmodule

// File: rtl/spi_rate_gen_dp.sv
module spi_rate_gen_dp
  import spi_rate_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgAddr,
  input  logic [CFG_W-1:0] cfgWdata,
  input  rateStrobe_t      stb,
  output logic             lastCnt,
  output logic             sclk,
  output logic             sclkRise,
  output logic             sclkFall
);

  logic [CODE_W-1:0] codeReg;
  logic              forceReg;
  logic [DIVF_W-1:0] divReg;
  logic [DIV_W-1:0]  activeDiv;
  logic [DIV_W-1:0]  cnt;
  logic [DIV_W-1:0]  nextDiv;
  logic [DIV_W-1:0]  nextCnt;
  logic              nextSclk;

  // staging registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg  <= CODE_W'(5);
      forceReg <= 1'b0;
      divReg   <= '0;
    end else if (cfgWe) begin
      if (cfgAddr) begin
        divReg <= cfgWdata[DIVF_W-1:0];
      end else begin
        codeReg  <= cfgWdata[CODE_W-1:0];
        forceReg <= cfgWdata[CODE_W];
      end
    end
  end

  always_comb begin
    lastCnt  = (cnt == activeDiv - DIV_W'(1));
    nextDiv  = stb.load ? decodeRatio(codeReg, forceReg, divReg) : activeDiv;
    nextCnt  = stb.wrap ? '0 : cnt + DIV_W'(1);
    // low phase takes the larger half
    nextSclk = (nextCnt >= nextDiv - (nextDiv >> 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeDiv <= DIV_W'(DIV_SLOW);
      cnt       <= '0;
      sclk      <= 1'b0;
      sclkRise  <= 1'b0;
      sclkFall  <= 1'b0;
    end else begin
      activeDiv <= nextDiv;
      cnt       <= nextCnt;
      sclk      <= nextSclk;
      sclkRise  <= nextSclk && !sclk;
      sclkFall  <= !nextSclk && sclk;
    end
  end

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_rate_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             engineBusy,
  input  logic             cfgWe,
  input  logic             cfgAddr,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic             sclk,
  output logic             sclkRise,
  output logic             sclkFall
);

  rateStrobe_t stb;
  logic        lastCnt;

  spi_rate_gen_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .engineBusy (engineBusy),
    .lastCnt    (lastCnt),
    .stb        (stb)
  );

  spi_rate_gen_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .stb      (stb),
    .lastCnt  (lastCnt),
    .sclk     (sclk),
    .sclkRise (sclkRise),
    .sclkFall (sclkFall)
  );

endmodule

// File: rtl/spi_rate_gen_chk.sv
module spi_rate_gen_chk (
  input logic clk,
  input logic rstN,
  input logic engineBusy,
  input logic sclk,
  input logic sclkRise,
  input logic sclkFall,
  input logic wrapStb,
  input logic loadStb
);

  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sclkRise && sclkFall));

  a_r8_rise_matches_level: assert property (@(posedge clk) disable iff (!rstN)
    sclkRise |-> (sclk && !$past(sclk)));

  a_r8_fall_matches_level: assert property (@(posedge clk) disable iff (!rstN)
    sclkFall |-> (!sclk && $past(sclk)));

  a_r8_edge_has_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (sclk != $past(sclk)) |-> (sclkRise || sclkFall));

  a_r9_load_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> !engineBusy);

  a_r9_load_only_boundary: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> wrapStb);

  a_r7_period_starts_low: assert property (@(posedge clk) disable iff (!rstN)
    wrapStb |=> !sclk);

endmodule

bind spi_rate_gen spi_rate_gen_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .engineBusy (engineBusy),
  .sclk       (sclk),
  .sclkRise   (sclkRise),
  .sclkFall   (sclkFall),
  .wrapStb    (stb.wrap),
  .loadStb    (stb.load)
);

// File: tb/spi_rate_gen_test.sv
`timescale 1ns/1ps
module spi_rate_gen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       engineBusy = 1'b0;
  logic       cfgWe = 1'b0;
  logic       cfgAddr = 1'b0;
  logic [5:0] cfgWdata = '0;
  logic       sclk, sclkRise, sclkFall;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  spi_rate_gen uut (
    .clk(clk), .rstN(rstN), .engineBusy(engineBusy),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .sclk(sclk), .sclkRise(sclkRise), .sclkFall(sclkFall)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finish();
    end
  end

  // R11: address 0 = mode (code in [3:0], force in [4]), address 1 = divider field
  task automatic writeReg(input bit addr, input logic [5:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = addr; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitRise();
    @(negedge clk);
    while (!sclkRise) @(negedge clk);
  endtask

  // Measure one full period between rises; count high cycles in it.
  task automatic measure(output int per, output int hi);
    per = 0; hi = 0;
    waitRise();
    do begin
      if (sclk) hi++;
      per++;
      @(negedge clk);
    end while (!sclkRise);
  endtask

  task automatic expectRate(input int n, input string tag);
    int per, hi;
    waitRise();
    waitRise();
    measure(per, hi);
    check(per == n, {tag, " period"}, per, n);
    check(hi == n / 2, {"R7 high phase (", tag, ")"}, hi, n / 2);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(sclk == 1'b0, "R1 sclk low in reset", int'(sclk), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(sclk == 1'b0 && !sclkRise && !sclkFall, "R1 outputs low after reset",
          int'({sclk, sclkRise, sclkFall}), 0);
    expectRate(250, "R1 default rate");
  endtask

  task automatic testFixed();
    int ratio[6] = '{3, 6, 9, 12, 2, 250};
    for (int c = 0; c < 6; c++) begin
      writeReg(1'b0, 6'(c));
      expectRate(ratio[c], $sformatf("R2 code %0d", c));
    end
  endtask

  task automatic testProg();
    writeReg(1'b1, 6'd4);
    writeReg(1'b0, 6'd7);
    expectRate(4, "R3 div 4");
    writeReg(1'b1, 6'h32);
    expectRate(50, "R3 div 50");
    writeReg(1'b1, 6'h3F);
    expectRate(63, "R3 div 63");
    writeReg(1'b1, 6'd5);
    expectRate(5, "R3 div 5 odd");
    writeReg(1'b1, 6'd0);
    expectRate(2, "R4 div 0");
    writeReg(1'b1, 6'd1);
    expectRate(2, "R4 div 1");
  endtask

  task automatic testReserved();
    writeReg(1'b0, 6'd6);
    expectRate(250, "R5 code 6");
    writeReg(1'b0, 6'd12);
    expectRate(250, "R5 code 12");
  endtask

  task automatic testForce();
    writeReg(1'b0, 6'h10);          // code 0, force set
    expectRate(2, "R6 force with code 0");
    writeReg(1'b0, 6'h15);          // code 5, force set
    expectRate(2, "R6 force with code 5");
  endtask

  task automatic testDivIgnored();
    writeReg(1'b0, 6'd0);
    expectRate(3, "R10 code 0 baseline");
    writeReg(1'b1, 6'd20);
    expectRate(3, "R10 divider ignored");
  endtask

  task automatic testBusyHold();
    int rises;
    writeReg(1'b0, 6'd1);
    expectRate(6, "R9 baseline");
    @(negedge clk);
    engineBusy = 1'b1;
    writeReg(1'b0, 6'd3);
    expectRate(6, "R9 held while busy");
    expectRate(6, "R9 still held while busy");
    // strobes keep toggling at the old rate
    rises = 0;
    repeat (24) begin
      @(negedge clk);
      if (sclkRise) rises++;
    end
    check(rises == 4, "R8 rise count over 24 cycles busy", rises, 4);
    engineBusy = 1'b0;
    expectRate(12, "R9 applied when idle");
  endtask

  initial begin
    testReset();
    testFixed();
    testProg();
    testReserved();
    testForce();
    testDivIgnored();
    testBusyHold();
    finish();
  end

endmodule